// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Translator

This block lets a processor read a serial NOR flash as if it were ordinary memory. A read request on a simple request/response bus carries a window offset. The block turns that offset into one complete serial read sequence: an opcode byte, then 1 to 4 address bytes, then an optional run of dummy clocks, then 32 data bits captured on one, two or four data lines. The four captured bytes come back as a single 32-bit word. Each sequence is built from scratch for each read, so the block has no cache and no prefetch.

Each chip select has its own setup word. The word holds the opcode, the address length, the dummy length and the data line count. A global window selector picks which chip select the window uses. A one-bit switch decides whether this block or a separate register-driven engine owns the serial pins. The block samples the setup word of the target chip select when it accepts a read. Setup writes made during a running sequence therefore take effect only from the next read onward.

Serial timing uses clock polarity 0 and phase 0, and SCLK runs at half the system clock. The block drives data while SCLK is low and samples while SCLK rises.

Top module: `mmflash_reader`

## Requirements
- R1: After reset every chip select is high, SCLK is low, no data line is driven, no response is pending, the request port is ready, and the switch is clear, so `mmapOwnsPins` is 0.
- R2: An accepted read first sends the opcode (setup bits 7:0) and then the address on IO0, most significant bit first, with `ioOe` = 4'b0001. Each bit occupies one SCLK period of two clocks, low then high. SCLK never pulses while every chip select is high.
- R3: Setup bits 9:8 hold the address length minus one. The block sends only that many low-order bytes of the bus offset, and the flash address equals the offset reduced to that length.
- R4: Setup bits 11:10 give a dummy byte count D. The block inserts 8*D SCLK periods after the address, and drives no data line during them.
- R5: Setup bits 13:12 select the data line count: 0 gives one line on IO1 (32 SCLK periods), 1 gives two lines on IO1:IO0 (16 periods), 3 gives four lines on IO3:IO0 (8 periods), and 2 is handled as one line. During the data phase no line is driven.
- R6: The returned word holds the byte at the lowest flash address in bits 7:0 and the next bytes above it. Within each byte the first bit received is the most significant. On several lines the highest-numbered line carries the more significant bit.
- R7: A window selector value of n+1 drives `csN[n]` low for the whole sequence, and only that select. `csN[n]` returns high at the same clock edge that raises `rdValid`.
- R8: `rdReady` is low from the accepting edge until the response. A successful response arrives 2*(8 + 8*address bytes + 8*D + data periods) clocks after the accepting edge.
- R9: If the switch is clear, or the selector is 0 or greater than the number of chip selects, the read is answered at the accepting edge with `rdErr` = 1 and `rdData` = 0, and no pin moves.
- R10: `mmapOwnsPins` follows the switch bit. If software clears the switch during a sequence, the output stays 1 until that sequence has responded.
- R11: A setup write to the chip select in use during a sequence does not change that sequence. The next read uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| setupWe | input | 1 | Setup word write strobe |
| setupIdx | input | 2 | Chip select whose setup word is written |
| setupData | input | 14 | Setup word: mode 13:12, dummy 11:10, address length-1 9:8, opcode 7:0 |
| switchWe | input | 1 | Switch write strobe |
| switchData | input | 1 | Switch value, 1 hands the pins to this block |
| csCode | input | 3 | Window chip select selector, n+1 picks select n, 0 disables |
| rdReq | input | 1 | Read request, taken on an edge where rdReady is high |
| rdAddr | input | 24 | Window byte offset of the read |
| rdReady | output | 1 | Block can accept a read |
| rdValid | output | 1 | One-cycle response strobe |
| rdData | output | 32 | Returned word |
| rdErr | output | 1 | Response refused (switch clear or selector invalid) |
| sclk | output | 1 | Serial clock |
| csN | output | 4 | Active-low chip selects |
| ioOut | output | 4 | Serial data lines driven out |
| ioOe | output | 4 | Output enables of the data lines |
| ioIn | input | 4 | Serial data lines read back |
| mmapOwnsPins | output | 1 | This block currently owns the serial pins |

## Verification
A bad phase counter or a stale setup snapshot shows up on the pins within the sequence it corrupts. The flash model in the bench then sees the wrong opcode or address bits, or the data lines stay enabled into the dummy or data phase. It also shows as a response latency different from twice the period count. A wrong chip select decode or a late deassertion is visible in the first SCLK period or at the response edge. A byte ordering or line-order slip corrupts the returned word of that same read. The bench uses a fresh address pattern for each read, so a slip cannot match the expected word by chance.

// File: rtl/mmflash_pkg.sv
package mmflash_pkg;

  localparam int OPC_W   = 8;
  localparam int SETUP_W = 14;
  localparam int ADDR_MAX_W = 32;
  localparam int TX_W    = OPC_W + ADDR_MAX_W;
  localparam int CNT_W   = $clog2(TX_W);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CMD   = 2'd1,
    PH_DUMMY = 2'd2,
    PH_DATA  = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    LN_ONE  = 2'd0,
    LN_TWO  = 2'd1,
    LN_FOUR = 2'd2
  } lanes_t;

  // field order follows the setup word bit layout (MSB first)
  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] dummy;
    logic [1:0] aw;
    logic [7:0] opcode;
  } setup_t;

  typedef struct packed {
    logic   load;
    logic   shift;
    logic   sample;
    logic   finish;
    logic   reject;
    lanes_t lanes;
  } strobes_t;

  function automatic lanes_t modeToLanes(input logic [1:0] m);
    case (m)
      2'd1:    return LN_TWO;
      2'd3:    return LN_FOUR;
      default: return LN_ONE;
    endcase
  endfunction

endpackage

// File: rtl/mmflash_ctrl.sv
module mmflash_ctrl
  import mmflash_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rdReq,
  input  logic     targetOk,
  input  setup_t   selSetup,
  output strobes_t stb,
  output logic     sclk,
  output logic [3:0] ioOe,
  output logic     busy,
  output logic     rdReady
);

  phase_t           phase;
  logic             half;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       dummyQ;
  lanes_t           lanesQ;
  logic             sclkQ;

  logic [CNT_W-1:0] cmdLast;
  logic [CNT_W-1:0] dummyLast;
  logic [CNT_W-1:0] dataLast;

  always_comb begin
    cmdLast   = CNT_W'({selSetup.aw, 3'b111}) + CNT_W'(8);
    dummyLast = CNT_W'({dummyQ, 3'b000}) - CNT_W'(1);
    case (lanesQ)
      LN_TWO:  dataLast = CNT_W'(15);
      LN_FOUR: dataLast = CNT_W'(7);
      default: dataLast = CNT_W'(31);
    endcase
  end

  always_comb begin
    stb       = '0;
    stb.lanes = lanesQ;
    if (phase == PH_IDLE) begin
      if (rdReq) begin
        stb.load   = targetOk;
        stb.reject = !targetOk;
      end
    end else if (!half) begin
      stb.sample = (phase == PH_DATA);
    end else begin
      stb.shift  = (phase == PH_CMD);
      stb.finish = (phase == PH_DATA) && (cnt == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      half   <= 1'b0;
      cnt    <= '0;
      dummyQ <= '0;
      lanesQ <= LN_ONE;
      sclkQ  <= 1'b0;
    end else if (phase == PH_IDLE) begin
      if (rdReq && targetOk) begin
        phase  <= PH_CMD;
        half   <= 1'b0;
        cnt    <= cmdLast;
        dummyQ <= selSetup.dummy;
        lanesQ <= modeToLanes(selSetup.mode);
      end
    end else if (!half) begin
      half  <= 1'b1;
      sclkQ <= 1'b1;
    end else begin
      half  <= 1'b0;
      sclkQ <= 1'b0;
      if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end else begin
        case (phase)
          PH_CMD: begin
            if (dummyQ != 2'd0) begin
              phase <= PH_DUMMY;
              cnt   <= dummyLast;
            end else begin
              phase <= PH_DATA;
              cnt   <= dataLast;
            end
          end
          PH_DUMMY: begin
            phase <= PH_DATA;
            cnt   <= dataLast;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign sclk    = sclkQ;
  assign ioOe    = (phase == PH_CMD) ? 4'b0001 : 4'b0000;
  assign busy    = (phase != PH_IDLE);
  assign rdReady = (phase == PH_IDLE);

  // R5: the data phase never counts past the length its line count allows
  p_data_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> (cnt <= dataLast));

endmodule

// File: rtl/mmflash_dp.sv
module mmflash_dp
  import mmflash_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  parameter int CODE_W = 3,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setupWe,
  input  logic [IDX_W-1:0]  setupIdx,
  input  logic [SETUP_W-1:0] setupData,
  input  logic              switchWe,
  input  logic              switchData,
  input  logic [CODE_W-1:0] csCode,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [3:0]        ioIn,
  input  strobes_t          stb,
  output setup_t            selSetup,
  output logic              targetOk,
  output logic              switchOn,
  output logic [NUM_CS-1:0] csN,
  output logic              txBit,
  output logic              rdValid,
  output logic              rdErr,
  output logic [31:0]       rdData
);

  setup_t setupAll [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_setup
    setup_t q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        q <= '0;
      else if (setupWe && setupIdx == IDX_W'(i))
        q <= setup_t'(setupData);
    end
    assign setupAll[i] = q;
  end

  logic switchQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         switchQ <= 1'b0;
    else if (switchWe) switchQ <= switchData;
  end
  assign switchOn = switchQ;

  logic             codeValid;
  logic [IDX_W-1:0] selIdx;
  assign codeValid = (csCode != '0) && (csCode <= CODE_W'(NUM_CS));
  assign selIdx    = IDX_W'(csCode - CODE_W'(1));
  assign selSetup  = codeValid ? setupAll[selIdx] : '0;
  assign targetOk  = codeValid && switchQ;

  // address moved up so that its first byte to send sits just below the opcode
  logic [ADDR_MAX_W-1:0] addrWide;
  logic [ADDR_MAX_W-1:0] addrAligned;
  assign addrWide    = ADDR_MAX_W'(rdAddr);
  assign addrAligned = addrWide << {~selSetup.aw, 3'b000};

  logic [TX_W-1:0] txQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          txQ <= '0;
    else if (stb.load)  txQ <= {selSetup.opcode, addrAligned};
    else if (stb.shift) txQ <= {txQ[TX_W-2:0], 1'b0};
  end
  assign txBit = txQ[TX_W-1];

  logic [31:0] rxQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxQ <= '0;
    end else if (stb.sample) begin
      case (stb.lanes)
        LN_TWO:  rxQ <= {rxQ[29:0], ioIn[1:0]};
        LN_FOUR: rxQ <= {rxQ[27:0], ioIn};
        default: rxQ <= {rxQ[30:0], ioIn[1]};
      endcase
    end
  end

  // first byte received lands in the lowest byte lane
  logic [31:0] swapped;
  for (genvar b = 0; b < 4; b++) begin : g_swap
    assign swapped[8*b +: 8] = rxQ[31-8*b -: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            csN <= '1;
    else if (stb.load)    csN <= ~(NUM_CS'(1) << selIdx);
    else if (stb.finish)  csN <= '1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdErr   <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.finish | stb.reject;
      if (stb.finish) begin
        rdErr  <= 1'b0;
        rdData <= swapped;
      end else if (stb.reject) begin
        rdErr  <= 1'b1;
        rdData <= '0;
      end
    end
  end

  // R7: at most one chip select active
  p_single_cs_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R9: a refused read carries an all-zero word
  p_reject_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdErr) |-> (rdData == '0));

endmodule

// File: rtl/mmflash_reader.sv
module mmflash_reader
  import mmflash_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         setupWe,
  input  logic [$clog2(NUM_CS)-1:0]    setupIdx,
  input  logic [13:0]                  setupData,
  input  logic                         switchWe,
  input  logic                         switchData,
  input  logic [$clog2(NUM_CS+1)-1:0]  csCode,
  input  logic                         rdReq,
  input  logic [ADDR_W-1:0]            rdAddr,
  output logic                         rdReady,
  output logic                         rdValid,
  output logic [31:0]                  rdData,
  output logic                         rdErr,
  output logic                         sclk,
  output logic [NUM_CS-1:0]            csN,
  output logic [3:0]                   ioOut,
  output logic [3:0]                   ioOe,
  input  logic [3:0]                   ioIn,
  output logic                         mmapOwnsPins
);

  localparam int CODE_W = $clog2(NUM_CS + 1);
  localparam int IDX_W  = $clog2(NUM_CS);

  strobes_t stb;
  setup_t   selSetup;
  logic     targetOk;
  logic     switchOn;
  logic     busy;
  logic     txBit;

  mmflash_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdReq    (rdReq),
    .targetOk (targetOk),
    .selSetup (selSetup),
    .stb      (stb),
    .sclk     (sclk),
    .ioOe     (ioOe),
    .busy     (busy),
    .rdReady  (rdReady)
  );

  mmflash_dp #(
    .NUM_CS (NUM_CS),
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W),
    .IDX_W  (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .setupWe    (setupWe),
    .setupIdx   (setupIdx),
    .setupData  (setupData),
    .switchWe   (switchWe),
    .switchData (switchData),
    .csCode     (csCode),
    .rdAddr     (rdAddr),
    .ioIn       (ioIn),
    .stb        (stb),
    .selSetup   (selSetup),
    .targetOk   (targetOk),
    .switchOn   (switchOn),
    .csN        (csN),
    .txBit      (txBit),
    .rdValid    (rdValid),
    .rdErr      (rdErr),
    .rdData     (rdData)
  );

  assign ioOut        = {3'b000, txBit};
  assign mmapOwnsPins = switchOn | busy;

  // R7: a select is low exactly while a sequence runs
  p_cs_tracks_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy == !(&csN));

  // R2: no clock pulse without a selected device
  p_sclk_needs_cs_r2: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !(&csN));

  // R10: the pins stay with this block while any select is low
  p_owner_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(&csN) |-> mmapOwnsPins);

endmodule

// File: tb/mmflash_reader_tb.sv
module mmflash_reader_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setupWe = 1'b0;
  logic [1:0]  setupIdx = '0;
  logic [13:0] setupData = '0;
  logic        switchWe = 1'b0;
  logic        switchData = 1'b0;
  logic [2:0]  csCode = '0;
  logic        rdReq = 1'b0;
  logic [23:0] rdAddr = '0;
  logic        rdReady, rdValid, rdErr, sclk, mmapOwnsPins;
  logic [31:0] rdData;
  logic [3:0]  csN, ioOut, ioOe;
  logic [3:0]  ioIn = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmflash_reader dut_i (
    .clk(clk), .rstN(rstN), .setupWe(setupWe), .setupIdx(setupIdx),
    .setupData(setupData), .switchWe(switchWe), .switchData(switchData),
    .csCode(csCode), .rdReq(rdReq), .rdAddr(rdAddr), .rdReady(rdReady),
    .rdValid(rdValid), .rdData(rdData), .rdErr(rdErr), .sclk(sclk),
    .csN(csN), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn),
    .mmapOwnsPins(mmapOwnsPins)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] flashByte(input longint a);
    return 8'((a * 13 + 7) ^ (a >> 5));
  endfunction

  // behavioural flash device
  int          edgeCnt = 0;
  int          cmdCyc = 16;
  int          dumCyc = 0;
  int          lanes = 1;
  int          nAddr = 1;
  int          dataPtr = 0;
  int          oeErr = 0;
  logic [39:0] cmdIn = '0;
  logic [31:0] stream = '0;
  logic [3:0]  csSeen = '1;
  longint      opRx = 0;
  longint      addrRx = 0;

  always @(posedge sclk) begin
    if (edgeCnt == 0) csSeen = csN;
    if (edgeCnt < cmdCyc) begin
      cmdIn = {cmdIn[38:0], ioOut[0]};
      if (ioOe != 4'b0001) oeErr++;
    end else if (ioOe != 4'b0000) begin
      oeErr++;
    end
    edgeCnt++;
    if (edgeCnt == cmdCyc) begin
      addrRx = longint'(cmdIn) & ((64'd1 << (8*nAddr)) - 1);
      opRx   = (longint'(cmdIn) >> (8*nAddr)) & 64'hFF;
      stream = {flashByte(addrRx), flashByte(addrRx+1),
                flashByte(addrRx+2), flashByte(addrRx+3)};
    end
  end

  always @(negedge sclk) begin
    if (edgeCnt >= cmdCyc + dumCyc && dataPtr < 32) begin
      case (lanes)
        2:       ioIn[1:0] = stream[31-dataPtr -: 2];
        4:       ioIn      = stream[31-dataPtr -: 4];
        default: ioIn[1]   = stream[31-dataPtr];
      endcase
      dataPtr += lanes;
    end
  end

  // compared on every clock: SCLK only moves with a select low
  always @(negedge clk) begin
    if (rstN && !done)
      chk(!(sclk && (&csN)), "R2", "sclk with no select", {63'd0, sclk}, 64'd0);
  end

  task automatic writeSetup(input int idx, input int mode, input int dum,
                            input int aw, input int op);
    @(negedge clk);
    setupWe   = 1'b1;
    setupIdx  = 2'(idx);
    setupData = {2'(mode), 2'(dum), 2'(aw), 8'(op)};
    @(negedge clk);
    setupWe   = 1'b0;
  endtask

  task automatic writeSwitch(input bit v);
    @(negedge clk);
    switchWe = 1'b1; switchData = v;
    @(negedge clk);
    switchWe = 1'b0;
  endtask

  // midAct: 0 none, 1 rewrite setup of the active select, 2 clear switch
  task automatic doRead(input int code, input logic [23:0] addr, input int op,
                        input int aw, input int dum, input int mode,
                        input bit expErr, input int midAct, input string req);
    int lat;
    int nPer;
    longint a;
    logic [31:0] expWord;
    bit readyBad;
    bit csMoved;
    nAddr   = aw + 1;
    cmdCyc  = 8 + 8*nAddr;
    dumCyc  = 8*dum;
    lanes   = (mode == 1) ? 2 : (mode == 3) ? 4 : 1;
    edgeCnt = 0; dataPtr = 0; oeErr = 0; csSeen = '1; cmdIn = '0;
    readyBad = 0; csMoved = 0;
    @(negedge clk);
    chk(rdReady == 1'b1, "R8", "ready before request", {63'd0, rdReady}, 64'd1);
    csCode = 3'(code); rdAddr = addr; rdReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdReq = 1'b0;
    lat = 0;
    while (!rdValid && lat < 4000) begin
      if (rdReady) readyBad = 1;
      if (lat == 10 && midAct == 1) begin
        setupWe = 1'b1; setupIdx = 2'(code-1);
        setupData = {2'd3, 2'd2, 2'd0, 8'hC7};
      end
      if (lat == 10 && midAct == 2) begin
        switchWe = 1'b1; switchData = 1'b0;
      end
      if (lat == 11) begin setupWe = 1'b0; switchWe = 1'b0; end
      if (lat == 14 && midAct == 2)
        chk(mmapOwnsPins == 1'b1, "R10", "owner held mid-sequence",
            {63'd0, mmapOwnsPins}, 64'd1);
      @(posedge clk);
      @(negedge clk);
      if (!(&csN)) csMoved = 1;
      lat++;
    end
    if (expErr) begin
      chk(lat == 0, "R9", "refusal latency", 64'(lat), 64'd0);
      chk(rdValid && rdErr, "R9", "error flag", {62'd0, rdValid, rdErr}, 64'd3);
      chk(rdData == 32'd0, "R9", "refused data", 64'(rdData), 64'd0);
      chk(edgeCnt == 0 && (&csN), "R9", "pins idle on refusal",
          64'(edgeCnt), 64'd0);
    end else begin
      nPer = cmdCyc + dumCyc + 32/lanes;
      a = longint'(addr) & ((64'd1 << (8*nAddr)) - 1);
      expWord = {flashByte(a+3), flashByte(a+2), flashByte(a+1), flashByte(a)};
      chk(!readyBad, "R8", "ready low while busy", {63'd0, readyBad}, 64'd0);
      chk(lat == 2*nPer, {req, "/R8"}, "response latency", 64'(lat), 64'(2*nPer));
      chk(rdErr == 1'b0, "R9", "no error on good read", {63'd0, rdErr}, 64'd0);
      chk(opRx == longint'(op), {req, "/R2"}, "opcode sent", 64'(opRx), 64'(op));
      chk(addrRx == a, {req, "/R3"}, "address sent", 64'(addrRx), 64'(a));
      chk(oeErr == 0, {req, "/R4"}, "line enables by phase", 64'(oeErr), 64'd0);
      chk(edgeCnt == nPer, {req, "/R5"}, "SCLK periods", 64'(edgeCnt), 64'(nPer));
      chk(csSeen == ~(4'b0001 << (code-1)), "R7", "selected chip",
          64'(csSeen), 64'(~(4'b0001 << (code-1))));
      chk(&csN, "R7", "select released with response", 64'(csN), 64'hF);
      chk(rdData == expWord, {req, "/R6"}, "returned word", 64'(rdData), 64'(expWord));
    end
    if (csMoved && expErr) chk(0, "R9", "select moved", 64'(csN), 64'hF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", "run did not finish", 64'd0, 64'd1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(&csN, "R1", "csN", 64'(csN), 64'hF);
    chk(!sclk, "R1", "sclk", {63'd0, sclk}, 64'd0);
    chk(ioOe == 4'd0, "R1", "ioOe", 64'(ioOe), 64'd0);
    chk(!rdValid && rdReady, "R1", "bus idle", {62'd0, rdValid, rdReady}, 64'd1);
    chk(!mmapOwnsPins, "R1", "owner", {63'd0, mmapOwnsPins}, 64'd0);

    writeSetup(0, 0, 0, 2, 8'h03);
    writeSetup(1, 1, 1, 2, 8'h3B);
    writeSetup(2, 3, 1, 3, 8'h6B);
    writeSetup(3, 2, 3, 0, 8'h0B);

    // R9: switch clear refuses the read
    doRead(1, 24'h000010, 8'h03, 2, 0, 0, 1, 0, "R9");

    writeSwitch(1);
    @(negedge clk);
    chk(mmapOwnsPins, "R10", "owner after switch set", {63'd0, mmapOwnsPins}, 64'd1);

    // R9: selector 0 and selector beyond the chip count
    doRead(0, 24'h000020, 8'h03, 2, 0, 0, 1, 0, "R9");
    doRead(5, 24'h000020, 8'h03, 2, 0, 0, 1, 0, "R9");

    // R2 R6 R7: single line, three address bytes, no dummy
    doRead(1, 24'h012345, 8'h03, 2, 0, 0, 0, 0, "R2");
    // R4 R5: dual lines with one dummy byte
    doRead(2, 24'h0A0B0C, 8'h3B, 2, 1, 1, 0, 0, "R4");
    // R3 R5: four address bytes, quad lines
    doRead(3, 24'hABCDEF, 8'h6B, 3, 1, 3, 0, 0, "R3");
    // R3 R5: one address byte, reserved mode 2 as single, three dummy bytes
    doRead(4, 24'h3456FE, 8'h0B, 0, 3, 2, 0, 0, "R5");

    // R3: two address bytes drop the high offset bits
    writeSetup(1, 3, 0, 1, 8'hEB);
    doRead(2, 24'h7FF0A5, 8'hEB, 1, 0, 3, 0, 0, "R3");

    // R11: setup rewrite during a sequence only affects the next read
    doRead(1, 24'h000777, 8'h03, 2, 0, 0, 0, 1, "R11");
    doRead(1, 24'h000040, 8'hC7, 0, 2, 3, 0, 0, "R11");

    // R10: switch cleared mid-sequence; ownership held until the response
    doRead(3, 24'h001234, 8'h6B, 3, 1, 3, 0, 2, "R10");
    chk(!mmapOwnsPins, "R10", "owner released after response",
        {63'd0, mmapOwnsPins}, 64'd0);
    doRead(3, 24'h001234, 8'h6B, 3, 1, 3, 1, 0, "R10");

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule